// File: doc/BRIEF.md
# Multiprocessor Serial Port

This block is an asynchronous serial transmitter and receiver. Software controls it through a small register window: one packed 8-bit control and status byte, a data location, and an interrupt enable byte. Writing the data location sends a byte. Reading it returns the last accepted byte. An external generator supplies one oversample tick per sixteenth of a bit period (`OSR` ticks per bit), and the block times every bit from those ticks.

There are three active frame formats. The first carries 8 data bits. The other two carry 9 data bits: the ninth bit comes from a control bit on transmit and is captured into a status bit on receive. A filter bit lets the receiver drop frames. In the 9-bit formats the receiver drops every frame whose ninth bit is 0, so a node on a shared line is interrupted only by address frames until software turns the filter off. In the 8-bit format the same bit drops frames that end with a low stop bit. The control value 00 selects a synchronous shift mode that this block does not implement, so that value parks both directions.

Top module: `mpsp_top`

## Requirements
- R1: After reset the control byte (address 0) and the enable byte (address 2) read 0, the data location (address 1) reads 0, `txd_o` is high and `irq_o` is low. Control byte layout: [7:6] frame mode, [5] filter, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit done, [0] receive done. Enable byte: [1] global, [0] serial.
- R2: A write to address 1 in a nonzero mode sends one low start bit, then the 8 data bits LSB first, then one high stop bit. Each bit lasts `OSR` ticks.
- R3: In modes 10 and 11 the control bit [3] is sent as a ninth bit between the data bits and the stop bit.
- R4: Transmit done is set when the stop bit ends. A write to address 1 while a frame is being sent is ignored.
- R5: In mode 01 a received frame stores its 8 data bits in the data location, copies the stop-bit level into control bit [2], and sets receive done.
- R6: In modes 10 and 11 a received frame stores its 8 data bits, copies the ninth bit into control bit [2], and sets receive done.
- R7: In modes 10 and 11 with the filter set, a frame whose ninth bit is 0 is discarded: receive done stays clear and the data location keeps its value.
- R8: In mode 01 with the filter set, a frame whose stop bit is low is discarded in the same way.
- R9: No frame is received while receive enable is 0. In mode 00 the block neither sends nor receives.
- R10: While receive done is set, no new frame is started, so the data location keeps its value.
- R11: Each bit is decided by the majority of three samples taken around its middle. A start bit that is not low at its middle returns the receiver to idle without a frame.
- R12: `irq_o` is high exactly when (transmit done or receive done) is set and both enable bits are 1.
- R13: The done flags are set only by hardware and change otherwise only through a software write to address 0, which loads all eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversample tick, `OSR` per bit period |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 data, 2 enables |
| wdata_i | input | PW | Write data |
| rdata_o | output | PW | Read data for `addr_i`, combinational |
| txd_o | output | 1 | Serial output, idles high |
| rxd_i | input | 1 | Serial input, asynchronous |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with `OSR` = 8, the default 8-bit data width, and a tick on every clock. A whole 11-bit frame therefore takes 88 clocks, which keeps the bench short enough to step through every mode and filter combination from a table. With a tick on every clock, a one-clock pulse on the line lands on exactly one of the three mid-bit samples. That makes the majority vote observable: a glitch placed on the centre sample of every bit, start and stop included, must leave the received byte intact. A two-clock low pulse, which is too short to count as a start bit, must be rejected as a false start.

// File: rtl/mpsp_pkg.sv
package mpsp_pkg;

    localparam logic [1:0] A_CTL  = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_IEN  = 2'd2;

    localparam logic [1:0] MD_SHIFT = 2'b00;

    typedef struct packed {
        logic [1:0] mode;
        logic       filt;
        logic       rx_on;
        logic       tx_b9;
        logic       rx_b9;
        logic       tx_done;
        logic       rx_done;
    } ctl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_e;

    function automatic logic is_nine(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/mpsp_tx.sv
module mpsp_tx #(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          go_i,
    input  logic [DW-1:0] data_i,
    input  logic          nine_i,
    input  logic          b9_i,
    output logic          txd_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int FW = DW + 3;
    localparam int BW = $clog2(FW + 1);

    typedef struct packed {
        logic          busy;
        logic [FW-1:0] sr;
        logic [BW-1:0] left;
        logic [CW-1:0] ph;
        logic          done;
    } tx_s;

    tx_s q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (!q.busy) begin
            if (go_i) begin
                n.busy = 1'b1;
                n.ph   = '0;
                if (nine_i) begin
                    n.sr   = {1'b1, b9_i, data_i, 1'b0};
                    n.left = BW'(FW);
                end else begin
                    n.sr   = {2'b11, data_i, 1'b0};
                    n.left = BW'(FW - 1);
                end
            end
        end else if (tick_i) begin
            if (q.ph == CW'(OSR - 1)) begin
                n.ph   = '0;
                n.sr   = {1'b1, q.sr[FW-1:1]};
                n.left = q.left - 1'b1;
                if (q.left == BW'(1)) begin
                    n.busy = 1'b0;
                    n.done = 1'b1;
                end
            end else begin
                n.ph = q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{busy: 1'b0, sr: '1, left: '0, ph: '0, done: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign txd_o  = q.busy ? q.sr[0] : 1'b1;
    assign busy_o = q.busy;
    assign done_o = q.done;

    // R2
    start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.busy) |-> !txd_o);

    // R2
    line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.busy && $past(q.busy) && !$past(tick_i)) |-> $stable(txd_o));

endmodule

// File: rtl/mpsp_rx.sv
module mpsp_rx
    import mpsp_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          rxd_i,
    input  logic          en_i,
    input  logic          nine_i,
    input  logic          filt_i,
    input  logic          hold_i,
    output logic          acc_o,
    output logic [DW-1:0] word_o,
    output logic          b9_o
);
    localparam int CW  = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int MID = OSR / 2;
    localparam int BW  = $clog2(DW + 2);

    typedef struct packed {
        logic          s1;
        logic          s2;
        rx_st_e        st;
        logic [CW-1:0] cnt;
        logic [1:0]    smp;
        logic [DW-1:0] sh;
        logic          b9;
        logic [BW-1:0] nb;
        logic          acc;
    } rx_s;

    rx_s q, n;
    logic maj;
    logic [BW-1:0] last_bit;

    always_comb begin
        maj      = (q.smp[0] & q.smp[1]) | (q.smp[0] & q.s2) | (q.smp[1] & q.s2);
        last_bit = nine_i ? BW'(DW) : BW'(DW - 1);
        n        = q;
        n.acc    = 1'b0;
        n.s1     = rxd_i;
        n.s2     = q.s1;
        if (q.st == RX_IDLE) begin
            if (tick_i && en_i && !hold_i && !q.s2) begin
                n.st  = RX_START;
                n.cnt = '0;
            end
        end else if (tick_i) begin
            n.cnt = (q.cnt == CW'(OSR - 1)) ? '0 : q.cnt + 1'b1;
            if (q.cnt == CW'(MID - 1) || q.cnt == CW'(MID)) begin
                n.smp = {q.smp[0], q.s2};
            end
            if (q.cnt == CW'(MID + 1)) begin
                unique case (q.st)
                    RX_START: begin
                        if (maj) begin
                            n.st = RX_IDLE;
                        end else begin
                            n.st = RX_DATA;
                            n.nb = '0;
                        end
                    end
                    RX_DATA: begin
                        if (q.nb < BW'(DW)) begin
                            n.sh = {maj, q.sh[DW-1:1]};
                        end else begin
                            n.b9 = maj;
                        end
                        n.nb = q.nb + 1'b1;
                        if (q.nb == last_bit) n.st = RX_STOP;
                    end
                    RX_STOP: begin
                        n.st = RX_IDLE;
                        if (nine_i) begin
                            n.acc = !filt_i || q.b9;
                        end else begin
                            n.b9  = maj;
                            n.acc = !filt_i || maj;
                        end
                    end
                    default: n.st = RX_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{s1: 1'b1, s2: 1'b1, st: RX_IDLE, cnt: '0, smp: 2'b11,
                   sh: '0, b9: 1'b0, nb: '0, acc: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign acc_o  = q.acc;
    assign word_o = q.sh;
    assign b9_o   = q.b9;

    // R10
    start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == RX_START && $past(q.st) == RX_IDLE) |-> $past(en_i && !hold_i));

    // R7
    addr_filter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_o && nine_i && filt_i) |-> b9_o);

endmodule

// File: rtl/mpsp_top.sv
module mpsp_top
    import mpsp_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8,
    localparam int PW = (DW > 8) ? DW : 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          wr_i,
    input  logic [1:0]    addr_i,
    input  logic [PW-1:0] wdata_i,
    output logic [PW-1:0] rdata_o,
    output logic          txd_o,
    input  logic          rxd_i,
    output logic          irq_o
);
    typedef struct packed {
        ctl_t          ctl;
        logic [DW-1:0] rxbuf;
        logic          ie_glob;
        logic          ie_sp;
    } top_s;

    top_s q, n;

    logic          tx_go, tx_busy, tx_done;
    logic          rx_acc, rx_b9;
    logic [DW-1:0] rx_word;
    logic          wr_ctl;

    always_comb begin
        wr_ctl = wr_i && (addr_i == A_CTL);
        tx_go  = wr_i && (addr_i == A_DATA) && (q.ctl.mode != MD_SHIFT) && !tx_busy;
        n      = q;
        if (wr_ctl) n.ctl = ctl_t'(wdata_i[7:0]);
        if (wr_i && addr_i == A_IEN) begin
            n.ie_glob = wdata_i[1];
            n.ie_sp   = wdata_i[0];
        end
        if (tx_done) n.ctl.tx_done = 1'b1;
        if (rx_acc) begin
            n.ctl.rx_done = 1'b1;
            n.ctl.rx_b9   = rx_b9;
            n.rxbuf       = rx_word;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        unique case (addr_i)
            A_CTL:   rdata_o = PW'(q.ctl);
            A_DATA:  rdata_o = PW'(q.rxbuf);
            A_IEN:   rdata_o = PW'({q.ie_glob, q.ie_sp});
            default: rdata_o = '0;
        endcase
    end

    assign irq_o = q.ie_glob && q.ie_sp && (q.ctl.tx_done || q.ctl.rx_done);

    mpsp_tx #(.OSR(OSR), .DW(DW)) u_tx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .go_i   (tx_go),
        .data_i (wdata_i[DW-1:0]),
        .nine_i (is_nine(q.ctl.mode)),
        .b9_i   (q.ctl.tx_b9),
        .txd_o  (txd_o),
        .busy_o (tx_busy),
        .done_o (tx_done)
    );

    mpsp_rx #(.OSR(OSR), .DW(DW)) u_rx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .rxd_i  (rxd_i),
        .en_i   (q.ctl.rx_on && (q.ctl.mode != MD_SHIFT)),
        .nine_i (is_nine(q.ctl.mode)),
        .filt_i (q.ctl.filt),
        .hold_i (q.ctl.rx_done),
        .acc_o  (rx_acc),
        .word_o (rx_word),
        .b9_o   (rx_b9)
    );

    // R13
    ri_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.ctl.rx_done) |-> $past(rx_acc || wr_ctl));

    // R13
    ti_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.ctl.tx_done && !wr_ctl) |=> q.ctl.tx_done);

    // R12
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(tx_done || rx_acc || wr_i));

endmodule

// File: tb/tb_mpsp_top.sv
module tb_mpsp_top;
    localparam int OSR = 8;
    localparam int PW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [PW-1:0] wdata = '0;
    logic [PW-1:0] rdata;
    logic txd, irq;
    logic rxd_drv = 1'b1;
    logic lpbk = 1'b0;
    logic rxd;
    int errors = 0;
    int checks = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;
    assign rxd = lpbk ? txd : rxd_drv;

    mpsp_top #(.OSR(OSR), .DW(8)) dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .txd_o(txd), .rxd_i(rxd), .irq_o(irq)
    );

    // {mode[1:0], filt, ren, b9, stop, data[7:0], acc, rb8}
    localparam logic [15:0] VEC [10] = '{
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b1},
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
        {2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 8'h81, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0},
        {2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 8'h12, 1'b1, 1'b1},
        {2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFE, 1'b1, 1'b0},
        {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1},
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 1'b0},
        {2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h66, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [PW-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [PW-1:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic send_rx(input logic [7:0] d, input logic nine, input logic b9,
                           input logic stp, input logic glitch);
        logic [10:0] fr;
        int nb;
        fr = nine ? {stp, b9, d, 1'b0} : {1'b1, stp, d, 1'b0};
        nb = nine ? 11 : 10;
        @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            for (int j = 0; j < OSR; j++) begin
                rxd_drv = (glitch && j == OSR / 2 + 1) ? ~fr[i] : fr[i];
                @(negedge clk);
            end
        end
        rxd_drv = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Sends one byte and captures the line at each bit centre; a second
    // write is issued during the fourth bit and must be ignored.
    task automatic tx_frame(input logic [7:0] d, input int nb, output logic [10:0] got);
        got = '1;
        @(negedge clk);
        wr = 1'b1; addr = 2'd1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        for (int c = 1; c <= nb * OSR; c++) begin
            if (c == 0 || c % OSR == OSR / 2) got[c / OSR] = txd;
            @(negedge clk);
            wr = (c == 3 * OSR);
            wdata = 8'hFF;
        end
        wr = 1'b0;
    endtask

    initial begin
        logic [PW-1:0] v, prev;
        logic [10:0] got;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        reg_rd(2'd0, v); chk("R1 ctl", 16'(v), 16'h0);
        reg_rd(2'd2, v); chk("R1 ien", 16'(v), 16'h0);
        reg_rd(2'd1, v); chk("R1 data", 16'(v), 16'h0);
        chk("R1 txd", 16'(txd), 16'h1);
        chk("R1 irq", 16'(irq), 16'h0);

        // Table walk over receive modes
        for (int k = 0; k < 10; k++) begin
            logic [1:0] md;
            logic fl, rn;
            md = VEC[k][15:14]; fl = VEC[k][13]; rn = VEC[k][12];
            if (!rn || md == 2'b00) tag = "R9";
            else if (md[1] && fl) tag = "R7";
            else if (md[1]) tag = "R6";
            else if (fl) tag = "R8";
            else tag = "R5";
            reg_wr(2'd0, {md, fl, rn, 4'b0000});
            reg_rd(2'd1, prev);
            send_rx(VEC[k][9:2], md[1], VEC[k][11], VEC[k][10], 1'b0);
            reg_rd(2'd0, v);
            chk({tag, " rx done"}, 16'(v[0]), 16'(VEC[k][1]));
            reg_rd(2'd1, v);
            chk({tag, " data"}, 16'(v), VEC[k][1] ? 16'(VEC[k][9:2]) : 16'(prev));
            if (VEC[k][1]) begin
                reg_rd(2'd0, v);
                chk({tag, " ninth"}, 16'(v[2]), 16'(VEC[k][0]));
            end
            repeat (2 * OSR) @(negedge clk);
        end

        // R10: a set receive-done flag blocks the next frame
        reg_wr(2'd0, 8'b01_0_1_0000);
        send_rx(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0);
        send_rx(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0);
        reg_rd(2'd1, v); chk("R10 held data", 16'(v), 16'hA5);
        reg_wr(2'd0, 8'b01_0_1_0000);
        send_rx(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0);
        reg_rd(2'd1, v); chk("R10 after clear", 16'(v), 16'h5A);

        // R11: centre-sample glitch on every bit, then a short false start
        reg_wr(2'd0, 8'b01_0_1_0000);
        send_rx(8'hC3, 1'b0, 1'b0, 1'b1, 1'b1);
        reg_rd(2'd1, v); chk("R11 majority", 16'(v), 16'hC3);
        reg_wr(2'd0, 8'b01_0_1_0000);
        @(negedge clk); rxd_drv = 1'b0;
        repeat (2) @(negedge clk); rxd_drv = 1'b1;
        repeat (3 * OSR) @(negedge clk);
        reg_rd(2'd0, v); chk("R11 false start", 16'(v[0]), 16'h0);
        send_rx(8'h96, 1'b0, 1'b0, 1'b1, 1'b0);
        reg_rd(2'd1, v); chk("R11 recovers", 16'(v), 16'h96);

        // R2, R4: 8-bit transmit with an ignored write mid-frame
        reg_wr(2'd0, 8'b01_0_0_0000);
        tx_frame(8'hA5, 10, got);
        chk("R2 frame", 16'(got[9:0]), 16'({1'b1, 8'hA5, 1'b0}));
        repeat (2) @(negedge clk);
        reg_rd(2'd0, v); chk("R4 tx done", 16'(v[1]), 16'h1);
        chk("R4 busy write ignored", 16'(txd), 16'h1);
        repeat (2 * OSR) @(negedge clk);
        chk("R4 line idle", 16'(txd), 16'h1);

        // R12: interrupt gating, R13: flag held until software write
        chk("R12 no enables", 16'(irq), 16'h0);
        reg_wr(2'd2, 8'h3);
        chk("R12 both enables", 16'(irq), 16'h1);
        reg_wr(2'd2, 8'h1);
        chk("R12 global off", 16'(irq), 16'h0);
        reg_wr(2'd2, 8'h2);
        chk("R12 serial off", 16'(irq), 16'h0);
        reg_wr(2'd2, 8'h3);
        reg_rd(2'd0, v); chk("R13 flag held", 16'(v[1]), 16'h1);
        reg_wr(2'd0, 8'b01_0_0_0000);
        chk("R13 cleared", 16'(irq), 16'h0);

        // R3: 9-bit transmit with loopback into the receiver
        lpbk = 1'b1;
        reg_wr(2'd0, 8'b11_0_1_1000);
        tx_frame(8'h3E, 11, got);
        chk("R3 frame", 16'(got), 16'({2'b11, 8'h3E, 1'b0}));
        repeat (4) @(negedge clk);
        reg_rd(2'd1, v); chk("R3 loopback data", 16'(v), 16'h3E);
        reg_rd(2'd0, v); chk("R3 loopback ninth", 16'(v[2]), 16'h1);
        lpbk = 1'b0;

        // R9: mode 00 sends nothing
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd1, 8'h0F);
        repeat (OSR) @(negedge clk);
        chk("R9 no start", 16'(txd), 16'h1);
        repeat (12 * OSR) @(negedge clk);
        reg_rd(2'd0, v); chk("R9 no tx done", 16'(v[1]), 16'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule